// File: doc/BRIEF.md
# Bit-Parallel Stream Matcher for a[0-9]*z

This block scans a byte stream for the pattern `a[0-9]*z`. Each valid input cycle carries a block of W bytes, and the block handles every one of those W positions in the same cycle. It splits the block into eight bit planes, one for each bit position of a byte. From these planes, bitwise logic alone builds three class planes: one for the letter `a`, one for the letter `z` and one for the decimal digits. A one-position advance, a single wide addition per star, and masking then turn these planes into marker streams. No automaton steps through the bytes one at a time.

The result is a W-bit plane. A one in it marks the character position directly after the `z` that ends a match. The output is registered and appears one clock after the input block. Three pieces of state link consecutive valid blocks, so a match can run across a block boundary: the top bit of each of the two advances, and the carry out of the star addition. A start-of-stream flag on a block discards that state.

Top module: `streamMatcher`

## Requirements
- R1: While reset is held and after its release, before any valid block, `matchPlane` is all zeros and `outValid` is 0.
- R2: `outValid` is 1 in the cycle after a cycle with `inValid` high and 0 otherwise. `matchPlane` changes only on the clock edge that accepts a valid block and holds its value through idle cycles.
- R3: Byte k of a block is `inBytes[8k+7:8k]`, and position k of a plane is bit k, with lower positions earlier in the stream. Bit p of `matchPlane` is 1 exactly when the byte at p-1 is `z` (0x7A) and ends a string `a` (0x61), zero or more digits (0x30..0x39), `z`. For p = 0, the byte at p-1 is the last byte of the previous valid block.
- R4: A zero-length digit run matches: `az` gives a match bit right after the `z`.
- R5: Only 0x61 counts as the start letter, only 0x7A as the end letter, and only 0x30..0x39 as digits. A neighbouring code such as `/` (0x2F), `:` (0x3A) or `A` (0x41) between the letters prevents the match.
- R6: A matching `z` in the last byte of a block makes bit 0 of the next valid block's `matchPlane` 1.
- R7: An `a` in the last byte of a block starts a match that the next valid block can complete.
- R8: A digit run that crosses a block boundary continues the match into the next valid block.
- R9: A block with `inStart` high ignores all history from earlier blocks. Its bit 0 is then 0, and no run carried in from before completes in it.
- R10: Cycles with `inValid` low leave the cross-block history unchanged, whatever `inBytes` holds during them.
- R11: Several matches in one block are all reported, and a failed attempt does not stop a later `a` from starting a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inBytes | input | W*8 | Block of W bytes, byte k in bits 8k+7..8k |
| inValid | input | 1 | Block on `inBytes` is accepted this cycle |
| inStart | input | 1 | Accepted block begins a new stream |
| matchPlane | output | W | Match-end bit per position, registered |
| outValid | output | 1 | `matchPlane` was updated on the last edge |

## Verification
The sample line `a4534q--b29z---az---a4q--bca22z` contains decoys such as `b29z` next to real matches, so it checks that the start letter is required. A line of near-miss codes (`/`, `:`, `A`) beside `a0z`, `a9z` and `az` checks that the class decode is exact at its edges. Pairs of blocks place `a`, `z` or the middle of a digit run at the boundary, once continuing and once with a start-of-stream flag, which separates correct carry handling from lost carries and from stale ones. Idle cycles with junk `z` bytes on the bus are inserted inside a split match to show that history moves only on valid blocks.

// File: rtl/streamMatchPkg.sv
package streamMatchPkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic load;   // accept the block and update history
    logic fresh;  // treat history as empty for this block
  } stepCtl_t;
endpackage

// File: rtl/charClassPlanes.sv
module charClassPlanes #(
  parameter int W = 32
) (
  input  logic [W*streamMatchPkg::CHAR_W-1:0] bytesIn,
  output logic [W-1:0]                        aPlane,
  output logic [W-1:0]                        zPlane,
  output logic [W-1:0]                        digitPlane
);
  localparam int CW = streamMatchPkg::CHAR_W;

  logic [CW-1:0][W-1:0] basis;

  for (genvar bitIdx = 0; bitIdx < CW; bitIdx++) begin : gPlane
    for (genvar pos = 0; pos < W; pos++) begin : gPos
      assign basis[bitIdx][pos] = bytesIn[pos*CW + bitIdx];
    end
  end

  // 0x61 = 0110_0001
  assign aPlane = ~basis[7] & basis[6] & basis[5] & ~basis[4]
                & ~basis[3] & ~basis[2] & ~basis[1] & basis[0];
  // 0x7A = 0111_1010
  assign zPlane = ~basis[7] & basis[6] & basis[5] & basis[4]
                & basis[3] & ~basis[2] & basis[1] & ~basis[0];
  // 0x30..0x39: high nibble 0011, low nibble 0..9
  assign digitPlane = ~basis[7] & ~basis[6] & basis[5] & basis[4]
                    & (~basis[3] | (~basis[2] & ~basis[1]));
endmodule

// File: rtl/streamCtrl.sv
module streamCtrl (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic                      inStart,
  output streamMatchPkg::stepCtl_t  ctl,
  output logic                      outValid
);
  always_comb begin
    ctl.load  = inValid;
    ctl.fresh = inValid & inStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/streamMatchCore.sv
module streamMatchCore #(
  parameter int W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  streamMatchPkg::stepCtl_t ctl,
  input  logic [W-1:0]             aPlane,
  input  logic [W-1:0]             zPlane,
  input  logic [W-1:0]             digitPlane,
  output logic [W-1:0]             matchPlane
);
  localparam int SUM_W = W + 1;

  logic carryA, carryStar, carryZ;
  logic effA, effStar, effZ;
  logic [W-1:0] m1, m2, hitZ, m3;
  logic [SUM_W-1:0] starSum;

  // history is dropped on a start-of-stream block
  assign effA    = ctl.fresh ? 1'b0 : carryA;
  assign effStar = ctl.fresh ? 1'b0 : carryStar;
  assign effZ    = ctl.fresh ? 1'b0 : carryZ;

  always_comb begin
    m1      = {aPlane[W-2:0], 1'b0} | {{(W-1){1'b0}}, effA};
    starSum = {1'b0, m1 & digitPlane} + {1'b0, digitPlane}
            + {{(SUM_W-1){1'b0}}, effStar};
    m2      = (starSum[W-1:0] ^ digitPlane) | m1;
    hitZ    = m2 & zPlane;
    m3      = {hitZ[W-2:0], 1'b0} | {{(W-1){1'b0}}, effZ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryA     <= 1'b0;
      carryStar  <= 1'b0;
      carryZ     <= 1'b0;
      matchPlane <= '0;
    end else if (ctl.load) begin
      carryA     <= aPlane[W-1];
      carryStar  <= starSum[W];
      carryZ     <= hitZ[W-1];
      matchPlane <= m3;
    end
  end
endmodule

// File: rtl/streamMatcher.sv
module streamMatcher #(
  parameter int W = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [W*streamMatchPkg::CHAR_W-1:0] inBytes,
  input  logic                               inValid,
  input  logic                               inStart,
  output logic [W-1:0]                       matchPlane,
  output logic                               outValid
);
  streamMatchPkg::stepCtl_t ctl;
  logic [W-1:0] aPlane, zPlane, digitPlane;

  streamCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart),
    .ctl(ctl), .outValid(outValid)
  );

  charClassPlanes #(.W(W)) uClass (
    .bytesIn(inBytes), .aPlane(aPlane), .zPlane(zPlane),
    .digitPlane(digitPlane)
  );

  streamMatchCore #(.W(W)) uCore (
    .clk(clk), .rstN(rstN), .ctl(ctl), .aPlane(aPlane),
    .zPlane(zPlane), .digitPlane(digitPlane), .matchPlane(matchPlane)
  );
endmodule

// File: rtl/matchChecker.sv
module matchChecker #(
  parameter int W = 32
) (
  input logic                               clk,
  input logic                               rstN,
  input logic [W*streamMatchPkg::CHAR_W-1:0] inBytes,
  input logic                               inValid,
  input logic                               inStart,
  input logic [W-1:0]                       matchPlane,
  input logic                               outValid
);
  localparam int CW = streamMatchPkg::CHAR_W;

  logic [W-1:0] zHere;
  logic prevTopZ;

  always_comb begin
    for (int k = 0; k < W; k++) zHere[k] = (inBytes[k*CW +: CW] == 8'h7A);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        prevTopZ <= 1'b0;
    else if (inValid) prevTopZ <= zHere[W-1];
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(matchPlane))); // R2
  AST_END_AFTER_Z: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ((matchPlane[W-1:1] & ~$past(zHere[W-2:0])) == '0)); // R3
  AST_BIT0_NEEDS_TOPZ: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !prevTopZ) |=> !matchPlane[0]); // R6
  AST_START_CLEARS_BIT0: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inStart) |=> !matchPlane[0]); // R9
endmodule

bind streamMatcher matchChecker #(.W(W)) uChk (.*);

// File: tb/sim_streamMatcher.sv
module sim_streamMatcher;
  localparam int W = 32;
  localparam int NB = W * 8;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NB-1:0] inBytes = '0;
  logic inValid = 1'b0;
  logic inStart = 1'b0;
  logic [W-1:0] matchPlane;
  logic outValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  streamMatcher #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .inBytes(inBytes), .inValid(inValid),
    .inStart(inStart), .matchPlane(matchPlane), .outValid(outValid)
  );

  // text written first character leftmost
  localparam logic [NB-1:0] TXT [NV] = '{
    "a4534q--b29z---az---a4q--bca22z-",
    "--------------------------------",
    "az-a/z-a:z-aAz-a0z-a9z-bz-aaz---",
    "-----------------------------a1z",
    "--------------------------------",
    "-------------------------------a",
    "7z------------------------------",
    "-----------------------------a45",
    "6z------------------------------",
    "-----------------------------a45",
    "6z------------------------------",
    "-----------------------------a1z",
    "--------------------------------",
    "a0123456789z-azaz09z-a99zz-zaaz-"
  };
  localparam logic VSTART [NV] = '{1,0,1,1,0,1,0,1,0,1,1,1,1,1};
  localparam logic [W-1:0] VEXP [NV] = '{
    32'h8002_0000, 32'h0, 32'h2044_0004, 32'h0, 32'h1, 32'h0, 32'h4,
    32'h0, 32'h4, 32'h0, 32'h0, 32'h0, 32'h0, 32'h8202_9000
  };
  string vReq [NV] = '{"R3", "R3", "R4 R5", "R6", "R6", "R7", "R7",
                       "R8", "R8", "R9", "R9", "R9", "R9", "R11"};

  function automatic logic [NB-1:0] toBus(input logic [NB-1:0] s);
    logic [NB-1:0] r;
    for (int k = 0; k < W; k++) r[8*k +: 8] = s[8*(W-1-k) +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendBlock(input logic [NB-1:0] bus, input logic st);
    @(negedge clk);
    inBytes = bus; inValid = 1'b1; inStart = st;
    @(posedge clk);
    #1;
    inValid = 1'b0; inStart = 1'b0;
  endtask

  task automatic idleCycle(input logic [NB-1:0] junk);
    @(negedge clk);
    inBytes = junk; inValid = 1'b0; inStart = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", matchPlane, '0);
    check("R1", {{(W-1){1'b0}}, outValid}, '0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", matchPlane, '0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      sendBlock(toBus(TXT[v]), VSTART[v]);
      check(vReq[v], matchPlane, VEXP[v]);
      check("R2", {{(W-1){1'b0}}, outValid}, 1);
    end

    // R2, R10: idle cycles with junk keep output and history
    sendBlock(toBus("-----------------------------a45"), 1'b1);
    held = matchPlane;
    for (int i = 0; i < 3; i++) begin
      idleCycle(toBus("zzzzzzzzzzzzzzzzzzzzzzzzzzzzzzzz"));
      check("R2", {{(W-1){1'b0}}, outValid}, 0);
      check("R2", matchPlane, held);
    end
    sendBlock(toBus("6z------------------------------"), 1'b0);
    check("R10", matchPlane, 32'h4);

    // R10: z at top, idle junk a's, then continuation gives bit0
    sendBlock(toBus("-----------------------------a1z"), 1'b1);
    idleCycle(toBus("aaaaaaaaaaaaaaaaaaaaaaaaaaaaaaaa"));
    sendBlock(toBus("--------------------------------"), 1'b0);
    check("R10", matchPlane, 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule